// File: doc/BRIEF.md
# Gated Hue Histogram Accumulator

This block builds the color signature of one scanned image block. A pixel stream arrives as a hue bin index, a flag saying the pixel passed both the minimum-brightness and minimum-colorfulness tests, and a strobe. Each qualifying pixel adds one to the counter of its bin. There are 36 bins, each covering ten degrees of hue, and each bin has a 12-bit counter.

A start-of-block pulse clears every counter at once. An end-of-block pulse freezes the counters. While the result is frozen, all 36 counts are available in parallel as one 432-bit signature word, which can be stored as a learned template or compared against one. The same counts can also be streamed bin by bin over a 12-bit bus, and a done pulse follows the last bin.

A block can be any size from a single pixel up to a full 128×64 frame, which is 8192 pixels. That is more than a 12-bit counter can hold, so the counters stop at their maximum value instead of wrapping.

Top module: `hue_sig_accum`

## Requirements
- R1: During accumulation, a cycle with `pix_vld`=1, `pix_pass`=1 and `pix_bin`=b, with b in 0..35, raises the count of bin b by exactly one and leaves every other bin unchanged.
- R2: A count that has reached 4095 stays at 4095 when more qualifying pixels arrive for that bin. It never wraps.
- R3: `blk_start` sets all 36 counts to zero in the following cycle, clears `sig_valid` and starts accumulation. A pixel presented in the same cycle as `blk_start` is not counted.
- R4: After reset and before the first `blk_start`, every pixel is ignored: all counts stay zero and `sig_valid` stays 0.
- R5: A pixel is not counted when `pix_pass`=0, when `pix_vld`=0, or when `pix_bin` is 36 or greater.
- R6: A pixel presented in the same cycle as `blk_end` is still counted. From the next cycle, `sig_valid` is 1 and further pixels leave the counts unchanged until the next `blk_start`.
- R7: Bin k occupies bits [12k+11:12k] of `sig_word`.
- R8: `rd_start` while the result is frozen and no readout is running starts a readout. From the next cycle, for 36 consecutive cycles, `rd_vld`=1, `rd_bin` steps 0,1,…,35 and `rd_data` carries that bin's count. `rd_start` is ignored while a readout is running or while the result is not frozen.
- R9: `rd_done` is high for exactly one cycle, the cycle right after the cycle that presents bin 35. At no other time is it high.
- R10: `blk_start` during a readout ends the readout in the next cycle, with `rd_vld`=0 and no `rd_done` pulse, and clears the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Clear counters and begin a new block |
| blk_end | input | 1 | Freeze counters after this cycle's pixel |
| pix_vld | input | 1 | Pixel strobe |
| pix_pass | input | 1 | Pixel passed both threshold tests |
| pix_bin | input | 6 | Hue bin index of the pixel |
| rd_start | input | 1 | Begin sequential readout |
| sig_word | output | 432 | All counts, bin k at bits [12k+11:12k] |
| sig_valid | output | 1 | Counts are frozen and complete |
| rd_vld | output | 1 | Readout word present |
| rd_bin | output | 6 | Bin index of the readout word |
| rd_data | output | 12 | Count of that bin |
| rd_done | output | 1 | One-cycle pulse after bin 35 |

## Verification
The hardest state to reach from the ports is a saturated counter. Getting there takes more than 4095 qualifying pixels into a single bin, all within one block. The stimulus streams 4100 passing pixels into one bin, ends the block with one more pixel in that same bin, and then checks the count both in the parallel word and in the serial readout. A second hard case is a readout aborted midway. The bench drops the pending expected items at the exact cycle of the abort, so any stray word or done pulse shows up as unexpected.

// File: rtl/hue_sig_pkg.sv
package hue_sig_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_ACCUM  = 2'd1,
      PH_FROZEN = 2'd2
   } phase_t;
endpackage

// File: rtl/hue_bin_counter.sv
module hue_bin_counter #(
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   logic step;

   generate
      if (SATURATE) begin : g_sat
         assign step = inc && (cnt != {CNT_W{1'b1}});
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/hue_seq_reader.sv
module hue_seq_reader #(
   parameter int NUM_BINS = 36,
   localparam int IDX_W   = $clog2(NUM_BINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             abort,
   output logic             active,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BINS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         done   <= 1'b0;
      end else if (abort) begin
         active <= 1'b0;
         idx    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (active) begin
            if (idx == LAST) begin
               active <= 1'b0;
               idx    <= '0;
               done   <= 1'b1;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
         end
      end
   end
endmodule

// File: rtl/hue_sig_accum.sv
module hue_sig_accum #(
   parameter int NUM_BINS = 36,
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1,
   localparam int IDX_W   = $clog2(NUM_BINS),
   localparam int SIG_W   = NUM_BINS * CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_start,
   input  logic             blk_end,
   input  logic             pix_vld,
   input  logic             pix_pass,
   input  logic [IDX_W-1:0] pix_bin,
   input  logic             rd_start,
   output logic [SIG_W-1:0] sig_word,
   output logic             sig_valid,
   output logic             rd_vld,
   output logic [IDX_W-1:0] rd_bin,
   output logic [CNT_W-1:0] rd_data,
   output logic             rd_done
);
   import hue_sig_pkg::*;

   generate
      if (NUM_BINS < 2) begin : g_bad_bins
         $error("hue_sig_accum: NUM_BINS must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_width
         $error("hue_sig_accum: CNT_W must be at least 1");
      end
   endgenerate

   phase_t           phase;
   logic             count_en;
   logic             bin_in_range;
   logic             rd_go;
   logic [CNT_W-1:0] cnt_arr [NUM_BINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              phase <= PH_IDLE;
      else if (blk_start)                      phase <= PH_ACCUM;
      else if (blk_end && phase == PH_ACCUM)   phase <= PH_FROZEN;
   end

   assign bin_in_range = {1'b0, pix_bin} < (IDX_W+1)'(NUM_BINS);
   assign count_en     = (phase == PH_ACCUM) && !blk_start &&
                         pix_vld && pix_pass && bin_in_range;

   generate
      for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
         hue_bin_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (blk_start),
            .inc   (count_en && (pix_bin == IDX_W'(g))),
            .cnt   (cnt_arr[g])
         );
         assign sig_word[g*CNT_W +: CNT_W] = cnt_arr[g];
      end
   endgenerate

   assign sig_valid = (phase == PH_FROZEN);
   assign rd_go     = rd_start && sig_valid && !rd_vld;

   hue_seq_reader #(
      .NUM_BINS (NUM_BINS)
   ) rdr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (rd_go),
      .abort  (blk_start),
      .active (rd_vld),
      .idx    (rd_bin),
      .done   (rd_done)
   );

   assign rd_data = rd_vld ? cnt_arr[rd_bin] : '0;
endmodule

// File: rtl/hue_sig_accum_chk.sv
module hue_sig_accum_chk #(
   parameter int NUM_BINS = 36,
   parameter int CNT_W    = 12,
   localparam int IDX_W   = $clog2(NUM_BINS),
   localparam int SIG_W   = NUM_BINS * CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             blk_start,
   input logic [SIG_W-1:0] sig_word,
   input logic             sig_valid,
   input logic             rd_vld,
   input logic [IDX_W-1:0] rd_bin,
   input logic             rd_done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BINS - 1);

   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         started <= 1'b0;
      else if (blk_start) started <= 1'b1;
   end

   a_r4_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (sig_word == '0) && !sig_valid);

   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (sig_word == '0) && !sig_valid);

   a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sig_valid && !blk_start |=> $stable(sig_word));

   a_r8_rd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> sig_valid);

   a_r8_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld && !blk_start && rd_bin != LAST
      |=> rd_vld && (rd_bin == $past(rd_bin) + IDX_W'(1)));

   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld && !blk_start && rd_bin == LAST |=> rd_done && !rd_vld);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld && blk_start |=> !rd_vld && !rd_done);

   generate
      for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin_chk
         a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
            !blk_start |=>
               (sig_word[g*CNT_W +: CNT_W] == $past(sig_word[g*CNT_W +: CNT_W])) ||
               (sig_word[g*CNT_W +: CNT_W] == $past(sig_word[g*CNT_W +: CNT_W]) + CNT_W'(1)));

         a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            !blk_start && (sig_word[g*CNT_W +: CNT_W] == {CNT_W{1'b1}})
            |=> sig_word[g*CNT_W +: CNT_W] == {CNT_W{1'b1}});
      end
   endgenerate
endmodule

bind hue_sig_accum hue_sig_accum_chk #(
   .NUM_BINS (NUM_BINS),
   .CNT_W    (CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .blk_start (blk_start),
   .sig_word  (sig_word),
   .sig_valid (sig_valid),
   .rd_vld    (rd_vld),
   .rd_bin    (rd_bin),
   .rd_done   (rd_done)
);

// File: tb/hue_sig_accum_tb.sv
module hue_sig_accum_tb_top;
   localparam int NB    = 36;
   localparam int CW    = 12;
   localparam int SIG_W = NB * CW;
   localparam int MAXC  = 4095;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             blk_start = 1'b0, blk_end = 1'b0;
   logic             pix_vld = 1'b0, pix_pass = 1'b0;
   logic [5:0]       pix_bin = '0;
   logic             rd_start = 1'b0;
   logic [SIG_W-1:0] sig_word;
   logic             sig_valid, rd_vld, rd_done;
   logic [5:0]       rd_bin;
   logic [CW-1:0]    rd_data;

   always #4 clk = ~clk;

   hue_sig_accum dut_i (
      .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_end(blk_end),
      .pix_vld(pix_vld), .pix_pass(pix_pass), .pix_bin(pix_bin),
      .rd_start(rd_start), .sig_word(sig_word), .sig_valid(sig_valid),
      .rd_vld(rd_vld), .rd_bin(rd_bin), .rd_data(rd_data), .rd_done(rd_done)
   );

   typedef struct { int bin; int cnt; } item_t;
   item_t expq[$];
   int    mdl [NB];
   bit    mdl_started = 0, mdl_frozen = 0;
   int    n_chk = 0, n_fail = 0;
   bit    prev_last = 0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cycle();
      @(posedge clk); #1;
      blk_start = 0; blk_end = 0; pix_vld = 0; pix_pass = 0; rd_start = 0;
   endtask

   function automatic void model_pix(int b, bit pass, bit vld);
      if (mdl_started && !mdl_frozen && vld && pass && b < NB && mdl[b] < MAXC)
         mdl[b]++;
   endfunction

   task automatic pix(int b, bit pass, bit vld = 1);
      pix_vld = vld; pix_pass = pass; pix_bin = 6'(b);
      model_pix(b, pass, vld);
      cycle();
   endtask

   task automatic start_blk(int b);
      blk_start = 1; pix_vld = 1; pix_pass = 1; pix_bin = 6'(b);
      foreach (mdl[k]) mdl[k] = 0;
      mdl_started = 1; mdl_frozen = 0;
      cycle();
   endtask

   task automatic end_blk(int b);
      blk_end = 1; pix_vld = 1; pix_pass = 1; pix_bin = 6'(b);
      model_pix(b, 1, 1);
      if (mdl_started) mdl_frozen = 1;
      cycle();
   endtask

   // R7: bin k sits at bits [12k+11:12k]
   task automatic check_sig(string req);
      @(negedge clk);
      for (int k = 0; k < NB; k++)
         check(sig_word[k*CW +: CW] == CW'(mdl[k]), req, $sformatf("R7 bin %0d", k),
               sig_word[k*CW +: CW], mdl[k]);
      check(sig_valid == mdl_frozen, req, "sig_valid", sig_valid, mdl_frozen);
   endtask

   task automatic push_all();
      for (int k = 0; k < NB; k++) begin
         item_t it;
         it.bin = k; it.cnt = mdl[k];
         expq.push_back(it);
      end
   endtask

   // Scoreboard monitor for the serial readout (R8, R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_vld) begin
            if (expq.size() == 0) check(0, "R8", "unexpected readout word", rd_bin, -1);
            else begin
               item_t it;
               it = expq.pop_front();
               check(rd_bin == 6'(it.bin), "R8", "rd_bin", rd_bin, it.bin);
               check(rd_data == CW'(it.cnt), "R8", "rd_data", rd_data, it.cnt);
            end
         end
         if (prev_last || rd_done) check(rd_done == prev_last, "R9", "rd_done", rd_done, prev_last);
         prev_last = rd_vld && rd_bin == 6'(NB - 1);
      end
   end

   task automatic readout(string req);
      push_all();
      rd_start = 1;
      cycle();
      repeat (4) @(posedge clk);
      #1 rd_start = 1;   // R8: ignored while busy
      cycle();
      repeat (NB) @(posedge clk);
      @(negedge clk);
      check(expq.size() == 0, req, "readout items left", expq.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      foreach (mdl[k]) mdl[k] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check(rd_vld == 0 && rd_done == 0, "R4", "reset readout idle", rd_vld, 0);
      check_sig("R4");

      // R4: pixels before the first block start are ignored
      for (int i = 0; i < 5; i++) pix(3, 1);
      check_sig("R4");

      // R3: start clears and drops its own pixel
      start_blk(7);
      check_sig("R3");

      // R1 and R5: mixed stimulus
      for (int i = 0; i < 9; i++) pix(0, 1);
      for (int i = 0; i < 4; i++) pix(35, 1);
      for (int i = 0; i < 6; i++) pix(7, 1);
      for (int i = 0; i < 5; i++) pix(7, 0);
      for (int i = 0; i < 3; i++) pix(12, 1, 0);
      for (int i = 0; i < 3; i++) pix(40, 1);
      pix(63, 1);
      for (int b = 0; b < NB; b += 5) pix(b, 1);
      check_sig("R1");
      check(sig_word[12*CW +: CW] == 0, "R5", "vld-low bin 12", sig_word[12*CW +: CW], 0);

      // R6: end pixel counted, later pixels ignored
      end_blk(2);
      check_sig("R6");
      for (int i = 0; i < 4; i++) pix(2, 1);
      check_sig("R6");

      // R8, R9: serial readout
      readout("R8");

      // R8: rd_start ignored while not frozen
      start_blk(1);
      pix(4, 1);
      rd_start = 1;
      cycle();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(rd_vld == 0, "R8", "rd_vld without frozen result", rd_vld, 0);
      end

      // R2: saturation
      for (int i = 0; i < 4100; i++) pix(5, 1);
      pix(6, 1);
      end_blk(5);
      check_sig("R2");
      check(sig_word[5*CW +: CW] == MAXC, "R2", "saturated bin", sig_word[5*CW +: CW], MAXC);
      readout("R2");

      // R10: abort readout with a block start
      push_all();
      rd_start = 1;
      cycle();
      @(posedge clk);
      @(posedge clk);
      #1 blk_start = 1;
      foreach (mdl[k]) mdl[k] = 0;
      mdl_frozen = 0;
      cycle();
      expq.delete();
      @(negedge clk);
      check(rd_vld == 0, "R10", "rd_vld after abort", rd_vld, 0);
      check_sig("R10");
      repeat (NB + 2) @(negedge clk);
      check(rd_vld == 0 && rd_done == 0, "R10", "no late readout or done", rd_done, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule